// File: doc/BRIEF.md
# Nine-bit serial command writer for a display controller

This block sends controller commands, each with its parameter bytes, to the write-only serial control port of an LCD panel. There is no data-out line on the panel side, so the block only transmits. A client hands over one request at a time: a command byte, a length code of zero, one or two parameter bytes, and a 16-bit data field. The block turns the request into a transaction of one, two or three 9-bit words. It frames that transaction with an active-low chip select and produces the serial clock by dividing the system clock.

Bit 8 of each word tells command from data: it is clear on the command word and set on every parameter word. A two-byte parameter is sent as two data words after a single command word, upper byte first. The serial clock idles high. The receiver samples on the rising (trailing) edge, so the block changes its data line only on falling edges. Chip select stays low, with no break, across all words of one transaction. It then stays high for a programmable gap before the next request can be taken. The client sees a valid/ready request handshake, a busy level and a one-cycle completion pulse.

Top module: `ninebit_cmd_tx`

## Requirements
- R1: Every word is 9 bits, shifted most significant bit first. The command word is {0, command byte} and a data word is {1, data byte}.
- R2: Length code 0 sends the command word alone. Code 1 sends the command, then data[7:0]. Code 2 sends the command, then data[15:8], then data[7:0]. Code 3 behaves like code 2.
- R3: spi_sclk is high whenever no bit is being clocked. spi_mosi changes only while spi_sclk is low and is stable across every rising edge of spi_sclk.
- R4: Each half period of spi_sclk lasts HALF_DIV system clocks. The first falling edge comes HALF_DIV cycles after the accepting clock edge.
- R5: spi_cs_n goes low at the accepting edge and stays low with no break through every word of the transaction. It goes high HALF_DIV cycles after the last rising edge of spi_sclk.
- R6: After spi_cs_n goes high, req_ready returns after GAP_TICKS*HALF_DIV more cycles. With the default GAP_TICKS of 2, that is at least one full serial clock period.
- R7: A request is taken only at a clock edge where req_valid and req_ready are both high. The fields are sampled at that edge only. req_valid and the fields have no effect while the block is busy.
- R8: done is a single-cycle pulse, raised in the same cycle in which spi_cs_n returns high.
- R9: busy is the inverse of req_ready. It is high from the accepting edge until req_ready returns.
- R10: While reset is applied: spi_cs_n=1, spi_sclk=1, spi_mosi=0, req_ready=1, busy=0 and done=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_cmd | input | 8 | Command byte |
| req_len | input | 2 | Number of parameter bytes (0, 1, 2; 3 acts as 2) |
| req_data | input | 16 | Parameter bytes; [7:0] alone for length 1, [15:8] then [7:0] for length 2 |
| busy | output | 1 | Transaction or trailing gap in progress |
| done | output | 1 | One-cycle pulse when chip select is released |
| spi_sclk | output | 1 | Serial clock, idle high |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the panel |

## Verification
The hardest situation to reach is a request that changes while the block is busy. The bench must show that it leaves no trace: no extra word, no altered word, and no shift in the gap timing. To reach it, the stimulus holds req_valid high with unrelated fields for many cycles inside a transaction. It drops req_valid before ready returns, and the cycle model confirms that the next accepted request is the only one that follows. Word boundaries are exercised with both data words carrying distinct bytes and with length code 3. The handover from one word to the next, where a new word is loaded on a falling edge instead of shifted, is checked in every cycle against the expected bit position.

// File: rtl/n9_pkg.sv
package n9_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = BYTE_W + 1;

  typedef logic [WORD_W-1:0] word9_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_TAIL,
    ST_GAP
  } seq_state_t;

  // action applied to the shift register at the next falling edge
  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_SHIFT,
    ACT_LOAD
  } edge_act_t;

  function automatic word9_t cmd_word(input logic [BYTE_W-1:0] b);
    return {1'b0, b};
  endfunction

  function automatic word9_t dat_word(input logic [BYTE_W-1:0] b);
    return {1'b1, b};
  endfunction

endpackage

// File: rtl/n9_tick_gen.sv
module n9_tick_gen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);

  localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign tick = run && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (run) begin
      if (cnt_q == CNT_LAST) cnt_d = '0;
      else                   cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST); // R4

  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/n9_req_hold.sv
module n9_req_hold
  import n9_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic [1:0]        len_i,
  input  logic [2*BYTE_W-1:0] data_i,
  input  logic [1:0]        sel_i,
  output word9_t            word_o,
  output logic [1:0]        last_o
);

  logic [BYTE_W-1:0]   cmd_q, cmd_d;
  logic [2*BYTE_W-1:0] data_q, data_d;
  logic [1:0]          last_q, last_d;

  always_comb begin
    cmd_d  = cmd_q;
    data_d = data_q;
    last_d = last_q;
    if (take) begin
      cmd_d  = cmd_i;
      data_d = data_i;
      last_d = (len_i == 2'd3) ? 2'd2 : len_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
      last_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      data_q <= data_d;
      last_q <= last_d;
    end
  end

  // word selection: index 1 carries the upper byte only for two-byte requests
  always_comb begin
    case (sel_i)
      2'd0:    word_o = cmd_word(cmd_q);
      2'd1:    word_o = (last_q == 2'd1) ? dat_word(data_q[BYTE_W-1:0])
                                         : dat_word(data_q[2*BYTE_W-1:BYTE_W]);
      default: word_o = dat_word(data_q[BYTE_W-1:0]);
    endcase
  end

  assign last_o = last_q;

  AST_LAST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    last_q <= 2'd2); // R2

endmodule

// File: rtl/n9_shifter.sv
module n9_shifter
  import n9_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_first,
  input  word9_t    first_word,
  input  logic      apply,
  input  edge_act_t act,
  input  word9_t    next_word,
  output logic      mosi
);

  word9_t sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load_first) begin
      sh_d = first_word;
    end else if (apply) begin
      case (act)
        ACT_SHIFT: sh_d = {sh_q[WORD_W-2:0], 1'b0};
        ACT_LOAD:  sh_d = next_word;
        default:   sh_d = sh_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign mosi = sh_q[WORD_W-1];

  AST_LOAD_DATA_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && act == ACT_LOAD) |=> sh_q[WORD_W-1]); // R1

  AST_FIRST_CMD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    load_first |=> !sh_q[WORD_W-1]); // R1

endmodule

// File: rtl/n9_seq.sv
module n9_seq
  import n9_pkg::*;
#(
  parameter int unsigned GAP_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       tick,
  input  logic [1:0] last_idx,
  output logic       accept,
  output logic       ready,
  output logic       sclk,
  output logic       cs_n,
  output logic       done,
  output logic       apply,
  output edge_act_t  act,
  output logic [1:0] word_sel
);

  localparam int unsigned BIT_W   = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);
  localparam int unsigned GAP_W   = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_TICKS - 1);

  seq_state_t       state_q, state_d;
  logic             sclk_q, sclk_d;
  logic             cs_n_q, cs_n_d;
  logic             done_q, done_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [1:0]       word_q, word_d;
  edge_act_t        act_q, act_d;
  logic [GAP_W-1:0] gap_q, gap_d;

  assign ready    = (state_q == ST_IDLE);
  assign accept   = ready && req_valid;
  assign apply    = tick && (state_q == ST_SHIFT) && sclk_q;
  assign act      = act_q;
  assign word_sel = word_q;
  assign sclk     = sclk_q;
  assign cs_n     = cs_n_q;
  assign done     = done_q;

  always_comb begin
    state_d = state_q;
    sclk_d  = sclk_q;
    cs_n_d  = cs_n_q;
    done_d  = 1'b0;
    bit_d   = bit_q;
    word_d  = word_q;
    act_d   = act_q;
    gap_d   = gap_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_SHIFT;
          cs_n_d  = 1'b0;
          sclk_d  = 1'b1;
          bit_d   = '0;
          word_d  = '0;
          act_d   = ACT_NONE;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          if (sclk_q) begin
            // falling edge: shifter applies act_q in this same cycle
            sclk_d = 1'b0;
            act_d  = ACT_NONE;
          end else begin
            // rising edge: the receiver takes the current bit
            sclk_d = 1'b1;
            if (bit_q == BIT_LAST) begin
              bit_d = '0;
              if (word_q == last_idx) begin
                state_d = ST_TAIL;
                act_d   = ACT_NONE;
              end else begin
                word_d = word_q + 1'b1;
                act_d  = ACT_LOAD;
              end
            end else begin
              bit_d = bit_q + 1'b1;
              act_d = ACT_SHIFT;
            end
          end
        end
      end
      ST_TAIL: begin
        if (tick) begin
          cs_n_d  = 1'b1;
          done_d  = 1'b1;
          gap_d   = '0;
          state_d = ST_GAP;
        end
      end
      ST_GAP: begin
        if (tick) begin
          if (gap_q == GAP_LAST) state_d = ST_IDLE;
          else                   gap_d   = gap_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b1;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      bit_q   <= '0;
      word_q  <= '0;
      act_q   <= ACT_NONE;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      sclk_q  <= sclk_d;
      cs_n_q  <= cs_n_d;
      done_q  <= done_d;
      bit_q   <= bit_d;
      word_q  <= word_d;
      act_q   <= act_d;
      gap_q   <= gap_d;
    end
  end

  AST_CLK_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_q |-> !cs_n_q); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R8

  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cs_n_q && !$past(cs_n_q))); // R8

  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= BIT_LAST); // R1

  AST_WORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    word_q <= last_idx); // R2

endmodule

// File: rtl/ninebit_cmd_tx.sv
module ninebit_cmd_tx
  import n9_pkg::*;
#(
  parameter int unsigned HALF_DIV  = 2,
  parameter int unsigned GAP_TICKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_cmd,
  input  logic [1:0]  req_len,
  input  logic [15:0] req_data,
  output logic        busy,
  output logic        done,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi
);

  logic       accept;
  logic       ready;
  logic       tick;
  logic       apply;
  edge_act_t  act;
  logic [1:0] word_sel;
  logic [1:0] last_idx;
  word9_t     next_word;

  n9_tick_gen #(
    .HALF_DIV (HALF_DIV)
  ) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (!ready),
    .clear (accept),
    .tick  (tick)
  );

  n9_req_hold u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (accept),
    .cmd_i  (req_cmd),
    .len_i  (req_len),
    .data_i (req_data),
    .sel_i  (word_sel),
    .word_o (next_word),
    .last_o (last_idx)
  );

  n9_seq #(
    .GAP_TICKS (GAP_TICKS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .tick      (tick),
    .last_idx  (last_idx),
    .accept    (accept),
    .ready     (ready),
    .sclk      (spi_sclk),
    .cs_n      (spi_cs_n),
    .done      (done),
    .apply     (apply),
    .act       (act),
    .word_sel  (word_sel)
  );

  n9_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_first (accept),
    .first_word (cmd_word(req_cmd)),
    .apply      (apply),
    .act        (act),
    .next_word  (next_word),
    .mosi       (spi_mosi)
  );

  assign req_ready = ready;
  assign busy      = !ready;

  AST_MOSI_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> $stable(spi_mosi)); // R3

  AST_FRAME_START_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(req_valid && req_ready)); // R7

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (spi_cs_n && spi_sclk)); // R9

endmodule

// File: tb/ninebit_cmd_tx_tb_top.sv
module ninebit_cmd_tx_tb_top;

  localparam int H = 3;
  localparam int G = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_cmd = '0;
  logic [1:0]  req_len = '0;
  logic [15:0] req_data = '0;
  logic        busy, done, spi_sclk, spi_cs_n, spi_mosi;

  always #10 clk = ~clk;

  ninebit_cmd_tx #(.HALF_DIV(H), .GAP_TICKS(G)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_len(req_len), .req_data(req_data), .busy(busy),
    .done(done), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;
  bit run_chk = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit         m_busy = 0;
  int         m = 0;
  int         m_nb = 9;
  logic [8:0] m_words [0:2];
  logic [8:0] exp_q [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0;
      m = 0;
    end else if (m_busy) begin
      m = m + 1;
      if (m == (2*m_nb + 1 + G)*H) m_busy = 0;
    end else if (req_valid) begin
      m_busy = 1;
      m = 0;
      m_words[0] = {1'b0, req_cmd};
      if (req_len == 2'd0) begin
        m_nb = 9;
      end else if (req_len == 2'd1) begin
        m_nb = 18;
        m_words[1] = {1'b1, req_data[7:0]};
      end else begin
        m_nb = 27;
        m_words[1] = {1'b1, req_data[15:8]};
        m_words[2] = {1'b1, req_data[7:0]};
      end
      for (int i = 0; i < m_nb/9; i++) exp_q.push_back(m_words[i]);
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (run_chk && rst_n) begin
      logic e_cs, e_sclk, e_done, e_rdy, e_bit;
      int bi;
      if (m_busy) begin
        e_cs   = (m >= (2*m_nb + 1)*H);
        e_sclk = (m >= H && m < 2*m_nb*H && (((m - H)/H) % 2 == 0)) ? 1'b0 : 1'b1;
        e_done = (m == (2*m_nb + 1)*H);
        e_rdy  = 1'b0;
      end else begin
        e_cs = 1'b1; e_sclk = 1'b1; e_done = 1'b0; e_rdy = 1'b1;
      end
      chk(spi_cs_n == e_cs, "R5 cs_n", spi_cs_n, e_cs);
      chk(spi_sclk == e_sclk, "R4 sclk", spi_sclk, e_sclk);
      chk(done == e_done, "R8 done", done, e_done);
      chk(req_ready == e_rdy, "R6 ready", req_ready, e_rdy);
      chk(busy == !e_rdy, "R9 busy", busy, !e_rdy);
      if (m_busy && !e_cs) begin
        bi = (m < H) ? 0 : (m - H)/(2*H);
        if (bi > m_nb - 1) bi = m_nb - 1;
        e_bit = m_words[bi/9][8 - (bi % 9)];
        chk(spi_mosi == e_bit, "R3 mosi", spi_mosi, e_bit);
      end
    end
  end

  // independent 9-bit mode-3 receiver
  logic [8:0] rx_sh = '0;
  int rx_cnt = 0;

  always @(posedge spi_sclk) begin
    if (rst_n === 1'b1 && spi_cs_n === 1'b0) begin
      rx_sh = {rx_sh[7:0], spi_mosi};
      rx_cnt++;
      if (rx_cnt == 9) begin
        rx_cnt = 0;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected word", rx_sh, 0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk(rx_sh == e, "R1 R2 word", rx_sh, e);
        end
      end
    end
  end

  always @(posedge spi_cs_n) begin
    if (rst_n === 1'b1 && rx_cnt != 0) chk(1'b0, "R5 partial word", rx_cnt, 0);
    rx_cnt = 0;
  end

  task automatic send(input logic [7:0] c, input logic [1:0] l, input logic [15:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_len = l; req_data = d;
    @(negedge clk);
    // scramble fields after the accepting edge (R7)
    req_valid = 1'b0; req_cmd = ~c; req_len = l ^ 2'b01; req_data = ~d;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(spi_cs_n == 1'b1, "R10 cs_n", spi_cs_n, 1);
    chk(spi_sclk == 1'b1, "R10 sclk", spi_sclk, 1);
    chk(spi_mosi == 1'b0, "R10 mosi", spi_mosi, 0);
    chk(req_ready == 1'b1, "R10 ready", req_ready, 1);
    chk(busy == 1'b0, "R10 busy", busy, 0);
    chk(done == 1'b0, "R10 done", done, 0);
    rst_n = 1'b1;
    run_chk = 1;

    send(8'h11, 2'd0, 16'hFFFF);   // R2 command only
    send(8'h3A, 2'd1, 16'hC360);   // R2 one byte: low byte only
    send(8'hC3, 2'd2, 16'h2040);   // R2 two bytes, high first
    send(8'hB8, 2'd3, 16'hFFF9);   // R2 code 3 acts as 2
    send(8'hFF, 2'd1, 16'hAB00);   // R1 flag bits with extreme bytes

    // R7: request noise while busy must leave no trace
    send(8'h29, 2'd0, 16'h0000);
    req_valid = 1'b1; req_cmd = 8'h55; req_len = 2'd2; req_data = 16'hA5A5;
    repeat (20) @(negedge clk);
    req_valid = 1'b0;

    send(8'hC7, 2'd2, 16'h5533);
    send(8'h00, 2'd2, 16'h01FE);   // back-to-back after gap (R6)
    send(8'h80, 2'd1, 16'h0081);
    wait_idle();

    chk(exp_q.size() == 0, "R2 all words received", exp_q.size(), 0);
    report();
  end

endmodule